// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number by reading a two-level translation tree from memory, with no help from software. A request carries the 20-bit virtual page number of a 32-bit address that uses 4 KB pages. The upper ten bits of that number select a word in the top-level table. The top-level table starts at the address held in a root register. The word that comes back points to a leaf table, and the lower ten bits of the page number select a word in that leaf table. The leaf word holds the physical page number. The 12-bit page offset never enters the block: it passes around it untranslated.

The walker makes one memory read per level over a simple port. The port has a one-cycle request strobe with an address, and a response strobe with a data word that may arrive any number of cycles later. Only one walk runs at a time, and a new request is taken only while the walker is idle. A walk ends in one of three ways, each signalled by a one-cycle pulse:
- a successful translation, which also carries a refill record for a translation cache;
- a page fault, raised when an entry at either level is absent;
- a trap to software, raised when the walker is switched off.

If the top-level entry is absent, the walk stops after a single read.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, and whenever reset is applied during a walk, the block is idle: `req_ready` is 1, and `mem_req_valid`, `done_pulse`, `pf_pulse` and `trap_pulse` are 0.
- R2: A request that is accepted with `walk_en` = 1 produces a first read, with `mem_req_valid` high for one cycle. Its address is `root_base` + 4 × top index, where the top index is `req_vpn[19:10]` (virtual address bits 31:22).
- R3: After a valid top-level entry, the second read address is {entry[31:12], 12'h000} + 4 × leaf index, where the leaf index is `req_vpn[9:0]` (virtual address bits 21:12).
- R4: Bit 0 of a table entry is its valid flag. A top-level entry with bit 0 = 0 ends the walk with `pf_pulse`, with no second read, and with `fault_vpn` equal to the requested page number.
- R5: A leaf entry with bit 0 = 0 ends the walk with `pf_pulse` after exactly two reads, and with `fault_vpn` equal to the requested page number.
- R6: When both entries are valid, `done_pulse` rises and `done_ppn` equals leaf entry bits 31:12. Entry bits 11:1 have no effect.
- R7: In the cycle of `done_pulse`, and only then, `fill_valid` is 1, `fill_vpn` holds the requested page number and `fill_ppn` holds the translated page number.
- R8: A request taken while `walk_en` = 0 makes no memory read and ends with `trap_pulse`, with `fault_vpn` equal to the requested page number.
- R9: Each outcome pulse lasts exactly one cycle. In the cycle after it, the walker is idle again with `req_ready` = 1.
- R10: A request is accepted only while `req_ready` = 1. A request presented during a walk is ignored: it does not change the result and starts no later walk.
- R11: The walker waits as long as needed for each response. It issues no further read and reports no outcome until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_en | input | 1 | 1 lets the walker run; 0 sends every request to the software trap |
| root_base | input | 32 | Byte address of the current top-level table |
| req_valid | input | 1 | Translation request strobe |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ready | output | 1 | High when idle and able to accept a request |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the table entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read back |
| done_pulse | output | 1 | One-cycle pulse on a successful translation |
| done_ppn | output | 20 | Translated physical page number |
| pf_pulse | output | 1 | One-cycle page-fault pulse |
| trap_pulse | output | 1 | One-cycle pulse when the walker is disabled |
| fault_vpn | output | 20 | Page number of the faulting or trapped request |
| fill_valid | output | 1 | Refill record valid |
| fill_vpn | output | 20 | Refill record: virtual page number |
| fill_ppn | output | 20 | Refill record: physical page number |

## Verification
The bench builds the walker with its default parameters: ten index bits per level, a 12-bit page offset and 32-bit entries. At these values the extreme indices 0x000, 0x200, 0x3FE and 0x3FF at both levels can be reached directly. The memory model places a sparse tree under two different roots and returns junk in the ignored entry bits. It also varies the response latency from one to four cycles, so early exit, leaf faults, waiting and busy-time requests are all exercised against addresses and page numbers that the bench computes itself.

// File: rtl/pt_walk_pkg.sv
// Shared types for the two-level table walker.
// Assumes nothing beyond a single clock domain.
package pt_walk_pkg;

    // Walk sequencer states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE_TOP,
        S_WAIT_TOP,
        S_ISSUE_LEAF,
        S_WAIT_LEAF,
        S_HIT,
        S_MISS
    } walk_state_e;

endpackage

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: steps through top read, leaf read and outcome states.
// Assumes the memory accepts a read in the cycle it is issued and
// answers with exactly one response per read.
module pt_walk_ctrl
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        walk_en,
    input  logic        req_valid,
    input  logic        rsp_valid,
    input  logic        rsp_ok,
    output walk_state_e state,
    output logic        trap_q
);

    walk_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (req_valid) state_nx = walk_en ? S_ISSUE_TOP : S_MISS;
            S_ISSUE_TOP:  state_nx = S_WAIT_TOP;
            S_WAIT_TOP:   if (rsp_valid) state_nx = rsp_ok ? S_ISSUE_LEAF : S_MISS;
            S_ISSUE_LEAF: state_nx = S_WAIT_LEAF;
            S_WAIT_LEAF:  if (rsp_valid) state_nx = rsp_ok ? S_HIT : S_MISS;
            S_HIT,
            S_MISS:       state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Records whether the pending miss is a disabled-walker trap.
    always_ff @(posedge clk) begin
        if (!rst_n)                           trap_q <= 1'b0;
        else if (state == S_IDLE && req_valid) trap_q <= !walk_en;
    end

    p_outcome_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIT || state == S_MISS) |=> state == S_IDLE);

    p_trap_skips_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MISS && trap_q) |-> $past(state) == S_IDLE);

    p_issue_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ISSUE_TOP |=> state == S_WAIT_TOP);

    p_wait_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_LEAF && !rsp_valid) |=> state == S_WAIT_LEAF);

    p_leaf_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ISSUE_LEAF |-> $past(rsp_valid && rsp_ok));

endmodule

// File: rtl/pt_walk_path.sv
// Walk datapath: holds the page number, the leaf table base and the
// result, and forms the entry address for each read.
// Assumes the root is 4-byte aligned and entries are 4 bytes wide.
module pt_walk_path
    import pt_walk_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  walk_state_e             state,
    input  logic                    req_valid,
    input  logic [2*IDX_W-1:0]      req_vpn,
    input  logic [PA_W-1:0]         root_base,
    input  logic                    rsp_valid,
    input  logic [PA_W-1:0]         rsp_data,
    output logic [2*IDX_W-1:0]      vpn_q,
    output logic [PA_W-OFF_W-1:0]   ppn_q,
    output logic [PA_W-1:0]         mem_addr
);

    localparam int VPN_W  = 2 * IDX_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int ENT_SH = 2;

    logic [PPN_W-1:0] base_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] leaf_idx;
    logic [PA_W-1:0]  top_addr;
    logic [PA_W-1:0]  leaf_addr;
    logic             unused_low;

    assign top_idx    = vpn_q[VPN_W-1:IDX_W];
    assign leaf_idx   = vpn_q[IDX_W-1:0];
    assign unused_low = ^rsp_data[OFF_W-1:0];

    // Captures the page number when a request is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                           vpn_q <= '0;
        else if (state == S_IDLE && req_valid) vpn_q <= req_vpn;
    end

    // Captures the leaf table base from the top-level entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                               base_q <= '0;
        else if (state == S_WAIT_TOP && rsp_valid) base_q <= rsp_data[PA_W-1:OFF_W];
    end

    // Captures the physical page number from the leaf entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ppn_q <= '0;
        else if (state == S_WAIT_LEAF && rsp_valid) ppn_q <= rsp_data[PA_W-1:OFF_W];
    end

    // Entry address for each level.
    always_comb begin
        top_addr  = root_base + (PA_W'(top_idx) << ENT_SH);
        leaf_addr = {base_q, OFF_W'(0)} + (PA_W'(leaf_idx) << ENT_SH);
        mem_addr  = (state == S_ISSUE_LEAF) ? leaf_addr : top_addr;
    end

    p_vpn_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(vpn_q));

    p_leaf_in_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ISSUE_LEAF |-> mem_addr[PA_W-1:OFF_W] == base_q);

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top: joins the sequencer and datapath and
// decodes the outcome pulses and the refill record.
// Assumes one outstanding read, and a response only after a request.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   walk_en,
    input  logic [PA_W-1:0]        root_base,
    input  logic                   req_valid,
    input  logic [2*IDX_W-1:0]     req_vpn,
    output logic                   req_ready,
    output logic                   mem_req_valid,
    output logic [PA_W-1:0]        mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [PA_W-1:0]        mem_rsp_data,
    output logic                   done_pulse,
    output logic [PA_W-OFF_W-1:0]  done_ppn,
    output logic                   pf_pulse,
    output logic                   trap_pulse,
    output logic [2*IDX_W-1:0]     fault_vpn,
    output logic                   fill_valid,
    output logic [2*IDX_W-1:0]     fill_vpn,
    output logic [PA_W-OFF_W-1:0]  fill_ppn
);

    localparam int VPN_W = 2 * IDX_W;
    localparam int PPN_W = PA_W - OFF_W;

    walk_state_e      state;
    logic             trap_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;

    pt_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .walk_en   (walk_en),
        .req_valid (req_valid),
        .rsp_valid (mem_rsp_valid),
        .rsp_ok    (mem_rsp_data[0]),
        .state     (state),
        .trap_q    (trap_q)
    );

    pt_walk_path #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .req_valid (req_valid),
        .req_vpn   (req_vpn),
        .root_base (root_base),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .vpn_q     (vpn_q),
        .ppn_q     (ppn_q),
        .mem_addr  (mem_req_addr)
    );

    // Outcome and handshake decode from the sequencer state.
    always_comb begin
        req_ready     = (state == S_IDLE);
        mem_req_valid = (state == S_ISSUE_TOP) || (state == S_ISSUE_LEAF);
        done_pulse    = (state == S_HIT);
        pf_pulse      = (state == S_MISS) && !trap_q;
        trap_pulse    = (state == S_MISS) && trap_q;
        done_ppn      = ppn_q;
        fault_vpn     = vpn_q;
        fill_valid    = (state == S_HIT);
        fill_vpn      = vpn_q;
        fill_ppn      = ppn_q;
    end

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, pf_pulse, trap_pulse}));

    p_read_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    typedef struct packed {
        logic [19:0] vpn;
        logic [31:0] root;
        logic        en;
        logic [2:0]  lat;
        logic [1:0]  kind;   // 0 done, 1 page fault, 2 trap
        logic [1:0]  nreq;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{20'h00000, 32'h0010_0000, 1'b1, 3'd1, 2'd0, 2'd2},
        '{20'h00401, 32'h0010_0000, 1'b1, 3'd2, 2'd1, 2'd1},
        '{20'h00401, 32'h0070_0000, 1'b1, 3'd3, 2'd0, 2'd2},
        '{20'hFFFFF, 32'h0070_0000, 1'b1, 3'd1, 2'd1, 2'd2},
        '{20'hFFBFE, 32'h0010_0000, 1'b1, 3'd2, 2'd0, 2'd2},
        '{20'h12345, 32'h0010_0000, 1'b0, 3'd1, 2'd2, 2'd0},
        '{20'h80000, 32'h0010_0000, 1'b1, 3'd4, 2'd0, 2'd2},
        '{20'h003FF, 32'h0010_0000, 1'b1, 3'd1, 2'd1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_en = 1'b1;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_pulse;
    logic [19:0] done_ppn;
    logic        pf_pulse;
    logic        trap_pulse;
    logic [19:0] fault_vpn;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;

    int nchk = 0;
    int nfail = 0;
    int got_kind;
    int got_nreq;
    logic [19:0] got_ppn;
    logic [19:0] got_fvpn;
    bit fill_ok;
    bit early;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .walk_en(walk_en), .root_base(root_base),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_pulse(done_pulse), .done_ppn(done_ppn), .pf_pulse(pf_pulse),
        .trap_pulse(trap_pulse), .fault_vpn(fault_vpn), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Sparse tree model. Root page 0x100 has valid top entries at even
    // indices, root page 0x700 at odd ones; leaf tables live at page
    // 0x200 + top index; leaf index 0x3FF is absent everywhere.
    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] rt);
        logic [19:0] pg;
        logic [9:0]  ix;
        logic [19:0] nb;
        logic [9:0]  ti;
        pg = a[31:12];
        ix = a[11:2];
        if (pg == rt[31:12]) begin
            nb = {10'h000, ix} + 20'h00200;
            if ((pg == 20'h00100 && !ix[0]) || (pg == 20'h00700 && ix[0]))
                return {nb, 12'hAA1};
            return 32'h0000_0FFE;
        end
        if (pg >= 20'h00200 && pg < 20'h00600) begin
            ti = 10'(pg - 20'h00200);
            if (ix != 10'h3FF) return {{ti, ix} ^ 20'hA5A5A, 12'hFFF};
            return 32'hFFFF_FFFE;
        end
        return 32'h0;
    endfunction

    task automatic run_walk(input vec_t v, input bit poke);
        int wait_cnt;
        bit pend;
        logic [31:0] paddr;
        logic [31:0] a1;
        logic [31:0] a2;
        wait_cnt = 0;
        pend = 0;
        paddr = '0;
        a1 = v.root + {20'h0, v.vpn[19:10], 2'b00};
        a2 = {{10'h000, v.vpn[19:10]} + 20'h00200, 12'h000} + {20'h0, v.vpn[9:0], 2'b00};
        got_kind = 3; got_nreq = 0; got_ppn = '0; got_fvpn = '0; fill_ok = 1; early = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v.vpn; root_base = v.root; walk_en = v.en;
        @(negedge clk);
        for (int c = 0; c < 60; c++) begin
            req_valid = 1'b0;
            mem_rsp_valid = 1'b0;
            if (done_pulse || pf_pulse || trap_pulse) begin
                got_kind = done_pulse ? 0 : (pf_pulse ? 1 : 2);
                got_ppn  = done_ppn;
                got_fvpn = fault_vpn;
                fill_ok  = (fill_valid == done_pulse) &&
                           (!done_pulse || (fill_vpn == v.vpn && fill_ppn == done_ppn));
                early    = pend;
                break;
            end
            if (pend) begin
                // R11: no new read while a response is outstanding
                if (mem_req_valid) check(1'b0, "R11 read while waiting", mem_req_addr, 32'h0);
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(paddr, v.root);
                    pend = 0;
                end else begin
                    wait_cnt--;
                end
            end else if (mem_req_valid) begin
                got_nreq++;
                if (got_nreq == 1) check(mem_req_addr == a1, "R2 top entry address", mem_req_addr, a1);
                else               check(mem_req_addr == a2, "R3 leaf entry address", mem_req_addr, a2);
                paddr = mem_req_addr;
                pend = 1;
                wait_cnt = int'(v.lat) - 1;
                if (poke && got_nreq == 1) begin
                    req_valid = 1'b1; req_vpn = 20'h00000; walk_en = 1'b1;
                end
            end
            @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        check(got_kind != 3, "R11 walk finished", 32'(got_kind), 32'd0);
        check(!early, "R11 outcome only after response", 32'(early), 32'd0);
        @(negedge clk);
        check(!done_pulse && !pf_pulse && !trap_pulse && req_ready,
              "R9 one-cycle pulse then idle",
              {28'h0, done_pulse, pf_pulse, trap_pulse, req_ready}, 32'h1);
    endtask

    task automatic judge(input vec_t v);
        string tag;
        logic [19:0] xppn;
        xppn = v.vpn ^ 20'hA5A5A;
        if (v.kind == 2'd0)      tag = "R6";
        else if (v.kind == 2'd2) tag = "R8";
        else if (v.nreq == 2'd1) tag = "R4";
        else                     tag = "R5";
        check(got_kind == int'(v.kind), {tag, " outcome kind"}, 32'(got_kind), 32'(v.kind));
        check(got_nreq == int'(v.nreq), {tag, " read count"}, 32'(got_nreq), 32'(v.nreq));
        if (v.kind == 2'd0) begin
            check(got_ppn == xppn, "R6 physical page", {12'h0, got_ppn}, {12'h0, xppn});
            check(fill_ok, "R7 refill record", 32'(fill_ok), 32'd1);
        end else begin
            check(got_fvpn == v.vpn, {tag, " fault page"}, {12'h0, got_fvpn}, {12'h0, v.vpn});
            check(fill_ok, "R7 no refill on fault", 32'(fill_ok), 32'd1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready && !mem_req_valid && !done_pulse && !pf_pulse && !trap_pulse,
              "R1 reset state", {27'h0, req_ready, mem_req_valid, done_pulse, pf_pulse, trap_pulse},
              32'h10);

        for (int i = 0; i < NVEC; i++) begin
            run_walk(VECS[i], 1'b0);
            judge(VECS[i]);
        end

        // R10: request during a walk is ignored
        run_walk(VECS[4], 1'b1);
        judge(VECS[4]);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!mem_req_valid && !done_pulse && !pf_pulse && req_ready,
                  "R10 busy request ignored", {29'h0, mem_req_valid, done_pulse, req_ready}, 32'h1);
        end

        // R1: reset applied in the middle of a walk
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 20'h00000; root_base = 32'h0010_0000; walk_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(!req_ready, "R1 walk in progress before reset", 32'(req_ready), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_req_valid && !done_pulse && !pf_pulse && !trap_pulse,
              "R1 idle after mid-walk reset",
              {27'h0, req_ready, mem_req_valid, done_pulse, pf_pulse, trap_pulse}, 32'h10);

        // R6: walker still translates correctly after the reset
        run_walk(VECS[6], 1'b0);
        judge(VECS[6]);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule